// File: doc/BRIEF.md
# Phase-switching multimodulus prescaler

This block divides a fast clock by a ratio between 64 and 71, chosen by a 3-bit mode word. A free-running divide-by-four front stage makes four square waves at a quarter of the input rate. Each wave is one input cycle behind the one before it. A multiplexer passes one of these waves to a divide-by-sixteen back counter. To lengthen the output period, the selector steps to the next lagging wave. Each step delays the chosen wave by exactly one input cycle, so the selector makes as many steps per output period as the mode word asks for.

A step is taken only while the current wave and the lagging wave are both low. The multiplexed signal therefore never shows a short pulse. The block takes at most one step per cycle of the selected wave. The mode word is read once per output period, in the input cycle that ends the period. The new value governs the whole of the following period, and the mode word has no effect at any other time. Everything is modelled synchronously to the input clock, which lets a surrounding divider chain use the period-end strobe directly.

Top module: `psw_prescaler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `period_end` is 0, `div_out` is 0 and `phase_out` is 1. The first `period_end` pulse comes exactly 64 input cycles after reset is released, whatever the mode.
- R2: The spacing between two consecutive `period_end` pulses is 64 + M input cycles. M is the value of `mode` at the clock edge that raises the earlier pulse.
- R3: Values of `mode` present at any other clock edge have no effect on the length of the period in progress.
- R4: `period_end` is high for exactly one input cycle per output period.
- R5: Every high interval of `phase_out` lasts exactly 2 cycles, and every low interval lasts 2 or 3 cycles. A phase step always moves the selection to the lagging wave, which stretches a low interval by one cycle.
- R6: Each output period contains exactly 16 rising edges of `phase_out`, and exactly M of its low intervals are 3 cycles long. At most one step is taken per selected-wave cycle.
- R7: `div_out` is 0 while `period_end` is high. Within each period it rises exactly once and falls exactly once, and the fall coincides with the period-end cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Number of extra input cycles per output period (0 to 7) |
| div_out | output | 1 | Divided clock, MSB of the back counter |
| period_end | output | 1 | One-cycle strobe in the first cycle of each new period |
| phase_out | output | 1 | Currently selected quarter-rate wave |

## Verification
The hardest case to reach is a change of the mode word partway through a period. Checking it needs the new value held at the one edge that samples it, after several other values have come and gone in the same period. The stimulus follows the expected next pulse. Until five cycles before that pulse it scrambles `mode` with pseudo-random values, and it then settles on a target that steps through all eight values. The bench tracks the resulting period lengths, counts of stretched low intervals and `div_out` edges for every period. It compares them with the value settled on, not with the values seen earlier in the period.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int DEF_PH_W   = 2;
    localparam int DEF_BACK_W = 4;
    localparam int DEF_MODE_W = 3;

    function automatic int nominal_ratio(input int ph_w, input int back_w);
        return (1 << ph_w) * (1 << back_w);
    endfunction
endpackage

// File: rtl/psw_quad_front.sv
module psw_quad_front import psw_pkg::*; #(
    parameter int PH_W = DEF_PH_W
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [(1<<PH_W)-1:0]   phases
);
    localparam int NPH  = 1 << PH_W;
    localparam int HALF = NPH / 2;

    typedef struct packed {
        logic [PH_W-1:0] cnt;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + PH_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // wave k is wave 0 delayed by k input cycles
    for (genvar k = 0; k < NPH; k++) begin : g_phase
        logic [PH_W-1:0] rel;
        assign rel       = st_q.cnt - PH_W'(k);
        assign phases[k] = (rel < PH_W'(HALF));
    end
endmodule

// File: rtl/psw_phase_select.sv
module psw_phase_select import psw_pkg::*; #(
    parameter int PH_W   = DEF_PH_W,
    parameter int MODE_W = DEF_MODE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [(1<<PH_W)-1:0]   phases,
    input  logic [MODE_W-1:0]      mode,
    input  logic                   wrap,
    output logic                   phase_out,
    output logic                   adv,
    output logic [PH_W-1:0]        sel
);
    typedef struct packed {
        logic [PH_W-1:0]   sel;
        logic [MODE_W-1:0] rem;
        logic              blk;
    } sel_t;

    sel_t st_d, st_q;

    logic [PH_W-1:0] lag_idx, lead_idx;
    logic            cur, lag, lead, do_sw;

    assign lag_idx  = st_q.sel + PH_W'(1);
    assign lead_idx = st_q.sel - PH_W'(1);
    assign cur      = phases[st_q.sel];
    assign lag      = phases[lag_idx];
    assign lead     = phases[lead_idx];

    // step only while current and lagging waves are both low
    assign do_sw = !cur && !lag && (st_q.rem != '0) && !st_q.blk;
    // selected wave rises next cycle: one back-counter tick
    assign adv   = !cur && lead && !do_sw;

    always_comb begin
        st_d = st_q;
        if (do_sw) begin
            st_d.sel = lag_idx;
            st_d.rem = st_q.rem - MODE_W'(1);
            st_d.blk = 1'b1;
        end
        if (adv) st_d.blk = 1'b0;
        if (wrap) st_d.rem = mode;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase_out = cur;
    assign sel       = st_q.sel;
endmodule

// File: rtl/psw_back_count.sv
module psw_back_count import psw_pkg::*; #(
    parameter int BACK_W = DEF_BACK_W
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic wrap,
    output logic div_out,
    output logic period_end
);
    typedef struct packed {
        logic [BACK_W-1:0] cnt;
        logic              pend;
    } back_t;

    back_t st_d, st_q;

    assign wrap = adv && (st_q.cnt == {BACK_W{1'b1}});

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + BACK_W'(adv);
        st_d.pend = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign div_out    = st_q.cnt[BACK_W-1];
    assign period_end = st_q.pend;
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler import psw_pkg::*; #(
    parameter int PH_W   = DEF_PH_W,
    parameter int BACK_W = DEF_BACK_W,
    parameter int MODE_W = DEF_MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output logic              div_out,
    output logic              period_end,
    output logic              phase_out
);
    localparam int NPH = 1 << PH_W;

    logic [NPH-1:0]  phases;
    logic            adv, wrap;
    logic [PH_W-1:0] sel_w;

    psw_quad_front #(.PH_W(PH_W)) u_front (
        .clk    (clk),
        .rst    (rst),
        .phases (phases)
    );

    psw_phase_select #(.PH_W(PH_W), .MODE_W(MODE_W)) u_select (
        .clk       (clk),
        .rst       (rst),
        .phases    (phases),
        .mode      (mode),
        .wrap      (wrap),
        .phase_out (phase_out),
        .adv       (adv),
        .sel       (sel_w)
    );

    psw_back_count #(.BACK_W(BACK_W)) u_back (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .wrap       (wrap),
        .div_out    (div_out),
        .period_end (period_end)
    );
endmodule

// File: rtl/psw_prescaler_chk.sv
module psw_prescaler_chk import psw_pkg::*; #(
    parameter int PH_W   = DEF_PH_W,
    parameter int BACK_W = DEF_BACK_W,
    parameter int MODE_W = DEF_MODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode,
    input logic              div_out,
    input logic              period_end,
    input logic              phase_out,
    input logic [PH_W-1:0]   sel
);
    localparam int NOM = nominal_ratio(PH_W, BACK_W);

    logic [MODE_W-1:0] mode_prev;
    int                gap;
    int                exp_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_prev <= '0;
            gap       <= 0;
            exp_len   <= NOM;
        end else begin
            mode_prev <= mode;
            if (period_end) begin
                gap     <= 1;
                exp_len <= NOM + int'(mode_prev);
            end else begin
                gap <= gap + 1;
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!period_end && !div_out && phase_out));

    assert_period_len_R2: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (gap == exp_len));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end);

    assert_high_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_out) |=> phase_out);

    assert_low_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_out) |=> !phase_out);

    assert_lag_step_R5: assert property (@(posedge clk) disable iff (rst)
        (sel != $past(sel)) |-> ((sel - $past(sel)) == PH_W'(1)));

    assert_div_low_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        period_end |-> !div_out);
endmodule

bind psw_prescaler psw_prescaler_chk #(
    .PH_W(PH_W), .BACK_W(BACK_W), .MODE_W(MODE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .div_out    (div_out),
    .period_end (period_end),
    .phase_out  (phase_out),
    .sel        (sel_w)
);

// File: tb/psw_prescaler_bench.sv
module psw_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       div_out, period_end, phase_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    psw_prescaler u_psw_prescaler (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .div_out    (div_out),
        .period_end (period_end),
        .phase_out  (phase_out)
    );

    always #2 clk = ~clk;

    task automatic ck(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, next_exp, exp_mode, run_len, rises, stretched;
        int div_rise, div_fall, periods, tgt_i;
        logic prev_ph, prev_div;
        logic [31:0] lcg;

        lcg = 32'h1234_5678;
        mode = 3'd5;  // value during reset must not matter (R1)
        repeat (4) @(posedge clk);
        @(negedge clk);
        ck(period_end == 1'b0, "R1 period_end in reset", int'(period_end), 0);
        ck(div_out == 1'b0,    "R1 div_out in reset",    int'(div_out), 0);
        ck(phase_out == 1'b1,  "R1 phase_out in reset",  int'(phase_out), 1);
        rst = 1'b0;

        n = 0; next_exp = 64; exp_mode = 0;
        run_len = 1; rises = 0; stretched = 0; div_rise = 0; div_fall = 0;
        periods = 0; tgt_i = 0;
        prev_ph = 1'b1; prev_div = 1'b0;

        while (periods < 26 && n < 5000) begin
            @(negedge clk);
            n++;
            // cycle-by-cycle reference comparison of the strobe (R2 R3 R4)
            ck(period_end == (n == next_exp), "R2 R3 R4 period_end timing",
               int'(period_end), int'(n == next_exp));

            if (phase_out != prev_ph) begin
                if (prev_ph) begin
                    ck(run_len == 2, "R5 high interval", run_len, 2);
                end else begin
                    ck(run_len == 2 || run_len == 3, "R5 low interval", run_len, 2);
                    if (run_len == 3) stretched++;
                    rises++;
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            if (div_out && !prev_div) div_rise++;
            if (!div_out && prev_div) div_fall++;

            if (n == next_exp) begin
                if (periods == 0) ck(n == 64, "R1 first period", n, 64);
                ck(!div_out, "R7 div_out at period end", int'(div_out), 0);
                ck(rises == 16, "R6 rising edges per period", rises, 16);
                ck(stretched == exp_mode, "R6 stretched low intervals", stretched, exp_mode);
                ck(div_rise == 1, "R7 div_out rises", div_rise, 1);
                ck(div_fall == 1, "R7 div_out falls", div_fall, 1);
                rises = 0; stretched = 0; div_rise = 0; div_fall = 0;
                exp_mode = int'(mode);
                next_exp = n + 64 + int'(mode);
                periods++;
                tgt_i++;
            end

            // settle target five cycles ahead, scramble before that (R3)
            if (n == next_exp - 5) begin
                mode = 3'((tgt_i * 5 + 1) % 8);
            end else if (n < next_exp - 5 && (n % 7) == 3) begin
                lcg  = lcg * 32'd1103515245 + 32'd12345;
                mode = lcg[18:16];
            end

            prev_ph  = phase_out;
            prev_div = div_out;
        end
        ck(periods == 26, "R2 periods completed", periods, 26);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule